// File: doc/BRIEF.md
# Streaming 64-Point Radix-4 FFT Pipeline

This block computes a forward 64-point discrete Fourier transform on a continuous stream of complex samples. It takes one complex sample per clock when its input strobe is high and, once a frame has filled the pipeline, delivers one complex result per accepted input. The transform is split into three radix-4 butterfly stages. Each stage keeps a feedback delay line. A twiddle rotation follows the first stage and another follows the second.

Both the input and output components are signed 10-bit two's complement numbers. Each butterfly divides its result by 4 with rounding, so a whole frame is scaled by 1/64 and the output stays at the input's word size. Results come out in base-4 digit-reversed bin order. A marker flags the first result of every output frame.

Top module: `fft64_r4sdf`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `out_valid` and `out_first` are 0. A reset in mid-frame restarts frame alignment, so the next 64 accepted samples form frame 0.
- R2: Each output frame equals the DFT of the matching input frame, X[k] = (1/64)·Σ x[n]·e^(−j2πnk/64), to within ±2 LSB on both the real and imaginary parts, for inputs of magnitude up to 450.
- R3: Output position p of a frame (p = 0..63) carries bin k = 16·(p mod 4) + 4·((p div 4) mod 4) + (p div 16). This is base-4 digit reversal.
- R4: `out_first` is 1 exactly on position 0 of each output frame and never while `out_valid` is 0.
- R5: Result number j, counted from reset over all accepted outputs, is presented right after clock edge t+4, where t is the edge that accepts input sample j+63.
- R6: A cycle with `in_valid` low is ignored. Its data is not used and no frame position advances, so a frame delivered with idle gaps gives the same results as a gap-free one.
- R7: `out_valid` rises once per accepted input after the first 63 inputs, and at no other time. When no input is accepted, `out_valid` is 0 from the fifth edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | 10 | Input real part, signed |
| in_im | input | 10 | Input imaginary part, signed |
| out_valid | output | 1 | Output result strobe |
| out_first | output | 1 | High on position 0 of an output frame |
| out_re | output | 10 | Output real part, signed |
| out_im | output | 10 | Output imaginary part, signed |

## Verification
A result depends on input sample j+63 and passes through five registers: stage, rotator, stage, rotator, stage. The bench records the clock edge at which each input is accepted. For every output it checks that the output appears exactly four edges after the acceptance of input j+63, and it checks this again on a frame sent with idle gaps. Data are captured only on cycles where `out_valid` is high, sampled on the falling edge. The captured frames are then compared against a DFT computed from the stored stimulus.

// File: rtl/fft64_pkg.sv
package fft64_pkg;

  localparam int DATA_W  = 10;
  localparam int TW_W    = 10;
  localparam int TW_FRAC = 8;
  localparam int N_PTS   = 64;
  localparam int N_STG   = 3;
  localparam int PW      = 2 * DATA_W + 1;

  typedef struct packed {
    logic signed [DATA_W-1:0] re;
    logic signed [DATA_W-1:0] im;
  } cplx_t;

  function automatic logic signed [PW-1:0] wd(input logic signed [DATA_W-1:0] v);
    return PW'(v);
  endfunction

  // clip a wide signed value into DATA_W bits
  function automatic logic signed [DATA_W-1:0] clip(input logic signed [PW-1:0] v);
    logic [PW-DATA_W:0] top;
    top = v[PW-1:DATA_W-1];
    if ((&top) || !(|top)) return v[DATA_W-1:0];
    else if (v[PW-1]) return {1'b1, {(DATA_W-1){1'b0}}};
    else return {1'b0, {(DATA_W-1){1'b1}}};
  endfunction

  // divide by 4 with round-half-up, then clip
  function automatic logic signed [DATA_W-1:0] quarter_rnd(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] t;
    t = (v + PW'(2)) >>> 2;
    return clip(t);
  endfunction

  // cosine over the first quadrant, 8 fractional bits
  function automatic logic signed [TW_W-1:0] qcos(input logic [4:0] m);
    case (m)
      5'd0:  return 10'sd256;
      5'd1:  return 10'sd255;
      5'd2:  return 10'sd251;
      5'd3:  return 10'sd245;
      5'd4:  return 10'sd237;
      5'd5:  return 10'sd226;
      5'd6:  return 10'sd213;
      5'd7:  return 10'sd198;
      5'd8:  return 10'sd181;
      5'd9:  return 10'sd162;
      5'd10: return 10'sd142;
      5'd11: return 10'sd121;
      5'd12: return 10'sd98;
      5'd13: return 10'sd74;
      5'd14: return 10'sd50;
      5'd15: return 10'sd25;
      default: return 10'sd0;
    endcase
  endfunction

  function automatic logic signed [TW_W-1:0] tw_cos(input logic [5:0] e);
    logic [4:0] m, mc;
    m  = {1'b0, e[3:0]};
    mc = 5'd16 - m;
    case (e[5:4])
      2'd0: return qcos(m);
      2'd1: return -qcos(mc);
      2'd2: return -qcos(m);
      default: return qcos(mc);
    endcase
  endfunction

  function automatic logic signed [TW_W-1:0] tw_sin(input logic [5:0] e);
    logic [4:0] m, mc;
    m  = {1'b0, e[3:0]};
    mc = 5'd16 - m;
    case (e[5:4])
      2'd0: return qcos(mc);
      2'd1: return qcos(m);
      2'd2: return -qcos(mc);
      default: return -qcos(m);
    endcase
  endfunction

endpackage

// File: rtl/fft64_r4_stage.sv
module fft64_r4_stage
  import fft64_pkg::*;
#(
  parameter int D = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  cplx_t in_x,
  output logic  out_valid,
  output cplx_t out_x
);

  localparam int CW    = $clog2(4 * D);
  localparam int DEPTH = 3 * D;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          primed_q, primed_d;
  logic          vld_q, vld_d;
  cplx_t         dat_q, dat_d;
  cplx_t         mem [DEPTH];

  logic          bfly_go;
  logic [CW-1:0] idx0, idx1, idx2;
  cplx_t         x0, x1, x2, x3, y0, y1, y2, y3;

  // butterfly phase is the last quarter of the count
  always_comb begin
    bfly_go = (cnt_q[CW-1 -: 2] == 2'd3);
    idx0    = cnt_q % CW'(D);
    idx1    = idx0 + CW'(D);
    idx2    = idx0 + CW'(2 * D);
    x0      = mem[idx0];
    x1      = mem[idx1];
    x2      = mem[idx2];
    x3      = in_x;
  end

  // radix-4 butterfly; the +-j terms swap real and imaginary parts
  always_comb begin
    y0.re = quarter_rnd(wd(x0.re) + wd(x1.re) + wd(x2.re) + wd(x3.re));
    y0.im = quarter_rnd(wd(x0.im) + wd(x1.im) + wd(x2.im) + wd(x3.im));
    y1.re = quarter_rnd(wd(x0.re) + wd(x1.im) - wd(x2.re) - wd(x3.im));
    y1.im = quarter_rnd(wd(x0.im) - wd(x1.re) - wd(x2.im) + wd(x3.re));
    y2.re = quarter_rnd(wd(x0.re) - wd(x1.re) + wd(x2.re) - wd(x3.re));
    y2.im = quarter_rnd(wd(x0.im) - wd(x1.im) + wd(x2.im) - wd(x3.im));
    y3.re = quarter_rnd(wd(x0.re) - wd(x1.im) - wd(x2.re) + wd(x3.im));
    y3.im = quarter_rnd(wd(x0.im) + wd(x1.re) - wd(x2.im) - wd(x3.re));
  end

  always_comb begin
    cnt_d    = in_valid ? cnt_q + CW'(1) : cnt_q;
    primed_d = primed_q | (in_valid & bfly_go);
    vld_d    = in_valid & (primed_q | bfly_go);
    dat_d    = bfly_go ? y0 : mem[cnt_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      vld_q    <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      dat_q <= dat_d;
      if (bfly_go) begin
        mem[idx0] <= y1;
        mem[idx1] <= y2;
        mem[idx2] <= y3;
      end else begin
        mem[cnt_q] <= in_x;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_x     = dat_q;

  // R6: idle input leaves frame position unchanged
  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));

  // R7: a result only follows an accepted input
  a_r7_stage_follow: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(in_valid));

endmodule

// File: rtl/fft64_twiddle_mul.sv
module fft64_twiddle_mul
  import fft64_pkg::*;
#(
  parameter int D = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  cplx_t in_x,
  output logic  out_valid,
  output cplx_t out_x
);

  localparam int CW   = $clog2(4 * D);
  localparam int STEP = N_PTS / (4 * D);

  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   vld_q;
  cplx_t                  dat_q, dat_d;
  logic [5:0]             expo;
  logic signed [PW-1:0]   wc, ws, ar, ai, pr, pi;

  always_comb begin
    expo = 6'(((int'(cnt_q) / D) * (int'(cnt_q) % D) * STEP) % N_PTS);
    wc   = PW'(tw_cos(expo));
    ws   = PW'(tw_sin(expo));
    ar   = wd(in_x.re);
    ai   = wd(in_x.im);
    // (a + jb)(c - js)
    pr   = ar * wc + ai * ws;
    pi   = ai * wc - ar * ws;
    dat_d.re = clip(pr >>> TW_FRAC);
    dat_d.im = clip(pi >>> TW_FRAC);
    cnt_d    = in_valid ? cnt_q + CW'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) dat_q <= dat_d;
  end

  assign out_valid = vld_q;
  assign out_x     = dat_q;

  // R6: rotation index frozen on idle cycles
  a_r6_mul_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));

  // R7: one output per accepted input
  a_r7_mul_follow: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(in_valid));

endmodule

// File: rtl/fft64_r4sdf.sv
module fft64_r4sdf
  import fft64_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  output logic                     out_first,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);

  localparam int D_FIRST = N_PTS / 4;
  localparam int NODES   = 2 * N_STG;
  localparam int OCW     = $clog2(N_PTS);

  cplx_t [NODES-1:0] nd_x;
  logic  [NODES-1:0] nd_v;
  logic  [OCW-1:0]   ocnt_q, ocnt_d;

  assign nd_v[0]    = in_valid;
  assign nd_x[0].re = in_re;
  assign nd_x[0].im = in_im;

  for (genvar s = 0; s < N_STG; s++) begin : g_stg
    fft64_r4_stage #(.D(D_FIRST >> (2 * s))) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (nd_v[2*s]),
      .in_x      (nd_x[2*s]),
      .out_valid (nd_v[2*s+1]),
      .out_x     (nd_x[2*s+1])
    );
    if (s < N_STG - 1) begin : g_mul
      fft64_twiddle_mul #(.D(D_FIRST >> (2 * s))) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (nd_v[2*s+1]),
        .in_x      (nd_x[2*s+1]),
        .out_valid (nd_v[2*s+2]),
        .out_x     (nd_x[2*s+2])
      );
    end
  end

  always_comb begin
    ocnt_d = nd_v[NODES-1] ? ocnt_q + OCW'(1) : ocnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ocnt_q <= '0;
    else        ocnt_q <= ocnt_d;
  end

  assign out_valid = nd_v[NODES-1];
  assign out_first = nd_v[NODES-1] & (ocnt_q == '0);
  assign out_re    = nd_x[NODES-1].re;
  assign out_im    = nd_x[NODES-1].im;

  // R4: marker only with a valid result
  a_r4_first_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  // R4: markers are a frame apart, never back to back
  a_r4_first_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |=> !out_first);

endmodule

// File: tb/test_fft64_r4sdf.sv
module test_fft64_r4sdf;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [9:0] in_re = '0;
  logic signed [9:0] in_im = '0;
  logic out_valid, out_first;
  logic signed [9:0] out_re, out_im;

  fft64_r4sdf i_fft64_r4sdf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_first(out_first), .out_re(out_re), .out_im(out_im)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0;
  int stim_re [8][64], stim_im [8][64];
  int cap_re [8][64], cap_im [8][64];
  int acc [700];
  int jin = 0, oidx = 0;
  int first_err = 0, first_cnt = 0, tim_err = 0, tim_act = 0, tim_exp = 0;
  int idle_win = 0, idle_hits = 0;
  logic [31:0] junk = 32'h1234_5678;

  // stimulus table: kind (0 impulse, 1 constant, 2 tone, 3 random), amplitude, position/bin/seed
  localparam int NV = 6;
  localparam int V_KIND [NV] = '{0, 1, 2, 2, 3, 2};
  localparam int V_AMP  [NV] = '{480, 400, 450, 300, 255, 420};
  localparam int V_ARG  [NV] = '{5, 0, 5, 37, 91, 63};
  localparam string V_TAG [NV] = '{"R2", "R2", "R3", "R3", "R2", "R3"};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) oidx = 0;
    else begin
      if (out_first && !out_valid) first_err++;
      if (idle_win != 0 && out_valid) idle_hits++;
      if (out_valid) begin
        if (oidx < 512) begin
          cap_re[oidx/64][oidx%64] = int'(out_re);
          cap_im[oidx/64][oidx%64] = int'(out_im);
        end
        if (out_first != ((oidx % 64) == 0)) first_err++;
        if (out_first) first_cnt++;
        if (oidx + 63 < 700 && cyc != acc[oidx+63] + 4 && tim_err == 0) begin
          tim_act = cyc - acc[oidx+63];
          tim_exp = 4;
        end
        if (oidx + 63 < 700 && cyc != acc[oidx+63] + 4) tim_err++;
        oidx++;
      end
    end
  end

  function automatic int digrev(int p);
    return (p % 4) * 16 + ((p / 4) % 4) * 4 + p / 16;
  endfunction

  task automatic make_frame(int f, int kind, int a, int b);
    logic [31:0] st = 32'(b) * 32'd2654435761 + 32'd7;
    for (int n = 0; n < 64; n++) begin
      real th = 6.283185307179586 * real'((b * n) % 64) / 64.0;
      case (kind)
        0: begin stim_re[f][n] = (n == b) ? a : 0; stim_im[f][n] = (n == b) ? -a / 2 : 0; end
        1: begin stim_re[f][n] = a; stim_im[f][n] = -(a * 3) / 4; end
        2: begin stim_re[f][n] = int'($rtoi($floor(a * $cos(th) + 0.5)));
                 stim_im[f][n] = int'($rtoi($floor(a * $sin(th) + 0.5))); end
        3: begin
             st = st * 32'd1103515245 + 32'd12345;
             stim_re[f][n] = int'((st >> 8) % 32'(2 * a + 1)) - a;
             st = st * 32'd1103515245 + 32'd12345;
             stim_im[f][n] = int'((st >> 8) % 32'(2 * a + 1)) - a;
           end
        default: begin stim_re[f][n] = 0; stim_im[f][n] = 0; end
      endcase
    end
  endtask

  task automatic put(int re, int im);
    @(negedge clk);
    in_valid = 1'b1;
    in_re = 10'(re);
    in_im = 10'(im);
    acc[jin] = cyc + 1;
    jin++;
  endtask

  task automatic idle();
    @(negedge clk);
    junk = junk * 32'd1664525 + 32'd1013904223;
    in_valid = 1'b0;
    in_re = junk[9:0];
    in_im = junk[25:16];
  endtask

  task automatic send_frame(int f, int gaps);
    for (int n = 0; n < 64; n++) begin
      if (gaps != 0 && (n % 3) == 1) begin idle(); idle(); end
      put(stim_re[f][n], stim_im[f][n]);
    end
  endtask

  task automatic check_frame(int f, string tag);
    int bad = 0, bp = 0, ar = 0, ai = 0;
    real er = 0.0, ei = 0.0;
    for (int p = 0; p < 64; p++) begin
      int k = digrev(p);
      real xr = 0.0, xi = 0.0;
      for (int n = 0; n < 64; n++) begin
        real th = 6.283185307179586 * real'((n * k) % 64) / 64.0;
        xr += stim_re[f][n] * $cos(th) + stim_im[f][n] * $sin(th);
        xi += stim_im[f][n] * $cos(th) - stim_re[f][n] * $sin(th);
      end
      xr = xr / 64.0;
      xi = xi / 64.0;
      if ((cap_re[f][p] - xr > 2.0) || (xr - cap_re[f][p] > 2.0) ||
          (cap_im[f][p] - xi > 2.0) || (xi - cap_im[f][p] > 2.0)) begin
        if (bad == 0) begin bp = p; ar = cap_re[f][p]; ai = cap_im[f][p]; er = xr; ei = xi; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s frame %0d pos %0d bin %0d: actual (%0d,%0d) expected (%0.2f,%0.2f), %0d bad",
               tag, f, bp, digrev(bp), ar, ai, er, ei, bad);
    end
  endtask

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog: actual %0d cycles expected under 20000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state, R1
    repeat (4) @(negedge clk);
    check_eq("R1 valid in reset", int'(out_valid), 0);
    check_eq("R1 first in reset", int'(out_first), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 valid after release", int'(out_valid), 0);

    // table of vectors, continuous frames 0..5
    for (int v = 0; v < NV; v++) make_frame(v, V_KIND[v], V_AMP[v], V_ARG[v]);
    make_frame(6, 3, 300, 77);
    make_frame(7, 4, 0, 0);
    for (int v = 0; v < NV; v++) send_frame(v, 0);
    send_frame(6, 1);      // R6: idle gaps carry junk data
    send_frame(7, 0);      // flush frame
    idle();
    repeat (6) idle();
    idle_win = 1;
    repeat (40) idle();
    idle_win = 0;

    for (int v = 0; v < NV; v++) check_frame(v, V_TAG[v]);
    check_frame(6, "R6");
    check_eq("R7 no output while idle", idle_hits, 0);
    check_eq("R7 output count", oidx, 512 - 63);
    check_eq("R4 marker placement errors", first_err, 0);
    check_eq("R4 marker count", first_cnt, 8);
    if (tim_err != 0) begin
      checks++; failures++;
      $display("FAIL R5 latency: actual %0d edges expected %0d (%0d late/early)", tim_act, tim_exp, tim_err);
    end else checks++;

    // mid-frame reset, R1
    for (int n = 0; n < 20; n++) put(137 - n, n * 9);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    jin = 0;
    first_cnt = 0;
    repeat (2) @(negedge clk);
    check_eq("R1 valid in mid-frame reset", int'(out_valid), 0);
    check_eq("R1 first in mid-frame reset", int'(out_first), 0);
    rst_n = 1'b1;
    make_frame(0, 1, -350, 0);
    make_frame(1, 2, 200, 17);
    make_frame(2, 4, 0, 0);
    send_frame(0, 0);
    send_frame(1, 0);
    send_frame(2, 0);
    repeat (8) idle();
    check_frame(0, "R1");
    check_frame(1, "R3");
    check_eq("R4 marker count after reset", first_cnt, 3);
    check_eq("R5 latency after reset", tim_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule